// File: doc/BRIEF.md
# Addressable Test-Access Latch Array

This block holds a set of single-bit state cells that sit on a functional path. In normal operation every cell captures its bit of the functional data bus on each clock. For test, the cells are reached one at a time by address rather than being chained into a shift register. Because nothing is shifted, each cell needs only one storage element.

In test mode a decoder turns the scan address into a one-hot select. Only the selected cell gets the scan clock enable, and only that cell captures the single scan-in bit. Each cell drives a per-cell observe bit. The selected cell drives its stored value and every other cell drives 1. The single scan-out line is the AND of all observe bits, so it shows the stored value of the addressed cell in the same cycle the address is applied. An address with no cell behind it selects nothing, and the scan-out then reads 1. A tester can therefore set or read any cell directly, without disturbing the others.

Top module: `ras_latch_array`

## Requirements
- R1: While rst_ni is low, every cell clears to 0 asynchronously, so func_q_o reads all zeros.
- R2: With test_mode_i = 0, every cell captures its bit of func_d_i on each rising clock edge. Bit k of func_q_o is the stored value of cell k.
- R3: With test_mode_i = 0, scan_in_i and scan_clk_en_i have no effect on any cell.
- R4: With test_mode_i = 1 and scan_clk_en_i = 1, the cell whose index equals scan_addr_i captures scan_in_i on the rising edge.
- R5: A scan write in test mode leaves every cell except the addressed one unchanged.
- R6: With test_mode_i = 1 and scan_clk_en_i = 0, all cells hold their values. A scan read by address is non-destructive, and func_d_i is ignored.
- R7: For scan_addr_i below NUM_CELLS, scan_out_o equals the stored value of that cell in the same cycle. This is combinational from the address and holds in either mode.
- R8: For scan_addr_i at or above NUM_CELLS (12 to 15 by default), no cell is selected, scan_out_o is 1, and a scan write changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional and scan clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | 1 selects addressed test access, 0 selects functional capture |
| scan_addr_i | input | ADDR_W | Index of the cell to read or write |
| scan_in_i | input | 1 | Bit written into the addressed cell |
| scan_clk_en_i | input | 1 | Gates the scan clock to the addressed cell |
| func_d_i | input | NUM_CELLS | Functional data, one bit per cell |
| func_q_o | output | NUM_CELLS | Stored cell values |
| scan_out_o | output | 1 | AND of all per-cell observe bits |

## Verification
Two functions can occur in the same cycle: a scan read of a cell and a scan write to that same cell. The bench addresses one cell and asserts scan_clk_en_i with a scan-in value that differs from the stored value. It samples scan_out_o before the edge, where the old value is expected, and func_q_o after the edge, where only the new bit of that cell may change. The bench also drops test_mode_i while scan_clk_en_i stays high. This shows that the functional capture wins and the scan bit is discarded.

// File: rtl/ras_pkg.sv
package ras_pkg;
  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ras_addr_decoder.sv
module ras_addr_decoder #(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CELLS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_dec
    assign sel_o[g] = (addr_i == ADDR_W'(g));
  end

  a_r8_one_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r8_none_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= NUM_CELLS) |-> (sel_o == '0));
endmodule

// File: rtl/ras_cell.sv
module ras_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_mode_i,
  input  logic sel_i,
  input  logic scan_clk_en_i,
  input  logic scan_in_i,
  input  logic func_d_i,
  output logic q_o,
  output logic obs_o
);
  logic scan_we;
  assign scan_we = test_mode_i & scan_clk_en_i & sel_i;

  // single storage element; test mode blocks functional capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= 1'b0;
    else if (!test_mode_i) q_o <= func_d_i;
    else if (scan_we)      q_o <= scan_in_i;
  end

  // unselected cells drive 1 into the AND network
  assign obs_o = sel_i ? q_o : 1'b1;
endmodule

// File: rtl/ras_obs_and.sv
module ras_obs_and #(
  parameter int N = 12
) (
  input  logic [N-1:0] obs_i,
  output logic         so_o
);
  localparam int P = (N > 1) ? (1 << $clog2(N)) : 1;
  logic [2*P-2:0] node;

  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < N) begin : g_used
      assign node[P-1+g] = obs_i[g];
    end else begin : g_pad
      assign node[P-1+g] = 1'b1;
    end
  end
  for (genvar g = 0; g < P-1; g++) begin : g_tree
    assign node[g] = node[2*g+1] & node[2*g+2];
  end
  assign so_o = node[0];
endmodule

// File: rtl/ras_latch_array.sv
module ras_latch_array
  import ras_pkg::*;
#(
  parameter int NUM_CELLS = 12,
  localparam int ADDR_W   = addr_width(NUM_CELLS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 test_mode_i,
  input  logic [ADDR_W-1:0]    scan_addr_i,
  input  logic                 scan_in_i,
  input  logic                 scan_clk_en_i,
  input  logic [NUM_CELLS-1:0] func_d_i,
  output logic [NUM_CELLS-1:0] func_q_o,
  output logic                 scan_out_o
);
  logic [NUM_CELLS-1:0] sel;
  logic [NUM_CELLS-1:0] obs;

  ras_addr_decoder #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(scan_addr_i),
    .sel_o (sel)
  );

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    ras_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .test_mode_i  (test_mode_i),
      .sel_i        (sel[g]),
      .scan_clk_en_i(scan_clk_en_i),
      .scan_in_i    (scan_in_i),
      .func_d_i     (func_d_i[g]),
      .q_o          (func_q_o[g]),
      .obs_o        (obs[g])
    );
  end

  ras_obs_and #(.N(NUM_CELLS)) u_and (
    .obs_i(obs),
    .so_o (scan_out_o)
  );

  // assertion arming: one edge after reset release
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r2_func_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(!test_mode_i)) |-> (func_q_o == $past(func_d_i)));
  a_r4_scan_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(test_mode_i && scan_clk_en_i && (int'(scan_addr_i) < NUM_CELLS)))
      |-> (func_q_o[$past(scan_addr_i)] == $past(scan_in_i)));
  a_r5_others_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(test_mode_i))
      |-> ((func_q_o & ~$past(sel)) == ($past(func_q_o) & ~$past(sel))));
  a_r6_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(test_mode_i && !scan_clk_en_i)) |-> $stable(func_q_o));
  a_r7_read_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(scan_addr_i) < NUM_CELLS) |-> (scan_out_o == func_q_o[scan_addr_i]));
  a_r8_read_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(scan_addr_i) >= NUM_CELLS) |-> scan_out_o);
endmodule

// File: tb/tb_ras_latch_array.sv
module tb_ras_latch_array;
  localparam int M = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic test_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sin = 1'b0;
  logic sen = 1'b0;
  logic [M-1:0] fd = '0;
  logic [M-1:0] fq;
  logic so;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ras_latch_array #(.NUM_CELLS(M)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .test_mode_i(test_mode),
    .scan_addr_i(addr), .scan_in_i(sin), .scan_clk_en_i(sen),
    .func_d_i(fd), .func_q_o(fq), .scan_out_o(so)
  );

  typedef struct packed {
    logic          mode;
    logic [3:0]    addr;
    logic          sin;
    logic          sen;
    logic [11:0]   fd;
    logic          exp_so;
    logic [11:0]   exp_q;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  1'b1, 1'b1, 12'hA5C, 1'b0, 12'hA5C, 4'd3}, // R3 scan ignored
    '{1'b0, 4'd3,  1'b0, 1'b0, 12'h3F1, 1'b1, 12'h3F1, 4'd2}, // R2
    '{1'b1, 4'd5,  1'b1, 1'b0, 12'hFFF, 1'b1, 12'h3F1, 4'd6}, // R6 hold
    '{1'b1, 4'd1,  1'b1, 1'b1, 12'h000, 1'b0, 12'h3F3, 4'd4}, // R4
    '{1'b1, 4'd11, 1'b1, 1'b1, 12'h000, 1'b0, 12'hBF3, 4'd5}, // R5 top cell
    '{1'b1, 4'd4,  1'b0, 1'b1, 12'hFFF, 1'b1, 12'hBE3, 4'd5}, // R5
    '{1'b1, 4'd13, 1'b0, 1'b1, 12'h000, 1'b1, 12'hBE3, 4'd8}, // R8
    '{1'b1, 4'd15, 1'b1, 1'b1, 12'h000, 1'b1, 12'hBE3, 4'd8}, // R8
    '{1'b1, 4'd11, 1'b0, 1'b0, 12'h000, 1'b1, 12'hBE3, 4'd7}, // R7
    '{1'b1, 4'd0,  1'b0, 1'b1, 12'h000, 1'b1, 12'hBE2, 4'd4}, // R4 cell 0
    '{1'b1, 4'd0,  1'b1, 1'b0, 12'h000, 1'b0, 12'hBE2, 4'd7}, // R7 reads written bit
    '{1'b0, 4'd12, 1'b0, 1'b1, 12'h5A5, 1'b1, 12'h5A5, 4'd8}, // R8 in normal mode
    '{1'b0, 4'd2,  1'b1, 1'b1, 12'h000, 1'b1, 12'h000, 4'd3}, // R3
    '{1'b1, 4'd2,  1'b1, 1'b1, 12'hFFF, 1'b0, 12'h004, 4'd4}, // R4 read+write same cycle
    '{1'b1, 4'd2,  1'b0, 1'b1, 12'h000, 1'b1, 12'h000, 4'd5}  // R5 clear back
  };

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_vec("R1 q during reset", fq, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    addr = 4'd7;
    #1 chk_bit("R7 read after reset", so, 1'b0);
    addr = 4'd12;
    #1 chk_bit("R8 read after reset", so, 1'b1);

    foreach (VEC[i]) begin
      @(negedge clk);
      test_mode = VEC[i].mode;
      addr = VEC[i].addr;
      sin = VEC[i].sin;
      sen = VEC[i].sen;
      fd = VEC[i].fd;
      #1 chk_bit($sformatf("R7/R%0d vec %0d scan_out", VEC[i].req, i), so, VEC[i].exp_so);
      @(posedge clk);
      #1 chk_vec($sformatf("R%0d vec %0d func_q", VEC[i].req, i), fq, VEC[i].exp_q);
    end

    // R6 long read sweep in test mode: all cells unchanged
    @(negedge clk);
    test_mode = 1'b1; sen = 1'b0; fd = 12'hFFF; sin = 1'b1;
    for (int a = 0; a < 16; a++) begin
      addr = AW'(a);
      @(posedge clk);
      #1;
    end
    chk_vec("R6 sweep hold", fq, 12'h000);

    // R1 async reset mid-run
    @(negedge clk);
    test_mode = 1'b0; fd = 12'hFFF;
    @(posedge clk);
    #1 chk_vec("R2 load all ones", fq, 12'hFFF);
    #2 rst_ni = 1'b0;
    #1 chk_vec("R1 async clear", fq, 12'h000);
    addr = 4'd11;
    #1 chk_bit("R1 scan_out after clear", so, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    finish_run();
  end
endmodule